// File: doc/BRIEF.md
# Bus turnaround idle-cycle inserter

This block sits between a bus master and an external memory bus that is divided into chip-select areas. It accepts one cycle request at a time, which carries an area index and a read/write flag. It announces the start of each accepted bus cycle with a one-clock strobe. When a write cycle to an area completes, the next cycle to that same area is held back by a programmed number of idle clocks. This gives slow devices time to turn their data pins around. Reads never cause idle clocks. A write to one area never delays a cycle to another area.

Each area has a 32-bit configuration word that software can write and read. A 3-bit field in that word selects the idle count through a non-linear code. A separate global word holds one bit that controls the memory strobe output-enable during standby and bus release. The per-area words survive a manual reset. Only a power-on reset returns them to their default.

Top module: `bus_turnaround_gap`

## Requirements
- R1: The idle field sits in bits 30:28 of each area word. It decodes 0→0, 1→1, 2→2, 3→4, 4→6, 5→8, 6→10 and 7→12 idle clocks.
- R2: Suppose a write cycle's `cyc_done_i` is high in clock k and a request to the same area is pending. Then `cyc_start_o` is high in clock k+1+N, where N is the decoded idle count of that area. This holds whether the new cycle is a read or a write.
- R3: After a read completes in clock k, a pending request to any area starts in clock k+1. The first request after either reset, presented in clock r, starts in clock r+1.
- R4: Idle clocks from a write apply only to its own area. A request to a different area after the write completes starts in clock k+1.
- R5: Area words are at addresses 0..7 and the global word is at address 8. `reg_rdata_o` shows the addressed word one clock after `reg_addr_i`. Bit 31 of every area word reads 0 whatever is written, and bits 30:0 read back as written.
- R6: Global word bit 0 is the keep-driven bit, and the other global bits read 0. One clock after its inputs, `strobe_oe_o` is 1 when neither standby nor bus release is active. Otherwise it equals the keep-driven bit (0 means floating). Standby does not alter any word.
- R7: Power-on reset sets every area word to 0x7000_0000 (idle code 7) and the keep-driven bit to 0. Manual reset leaves all words unchanged, but it cancels the current cycle and any pending idle clocks.
- R8: While a request waits, `cyc_start_o` stays low. A request seen during a clock in which `cyc_start_o` is high is not accepted.
- R9: During and immediately after reset, `cyc_start_o`, `strobe_oe_o` and `reg_rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| man_rst | input | 1 | Synchronous manual reset, active high; keeps configuration |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address (0..7 area words, 8 global word) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data for the address of the previous clock |
| req_valid_i | input | 1 | Cycle request pending |
| req_area_i | input | 3 | Area index of the request |
| req_write_i | input | 1 | 1 for a write request, 0 for a read |
| cyc_done_i | input | 1 | The current bus cycle completes in this clock |
| cyc_start_o | output | 1 | One-clock strobe: a bus cycle begins |
| cyc_area_o | output | 3 | Area of the cycle in progress |
| cyc_write_o | output | 1 | Direction of the cycle in progress |
| standby_i | input | 1 | Standby mode active |
| bus_rel_i | input | 1 | Bus released to another master |
| strobe_oe_o | output | 1 | Output-enable for strobes and memory clock |

## Verification
The start strobe is registered. A cycle that completes in clock k therefore lets a new cycle show its strobe in clock k+1+N. The bench asserts the completion and the next request at the same falling edge. It then counts the falling edges until it sees the strobe, and compares that count with N+1 computed from the code. Register reads and the output-enable are each one register deep, so the bench samples them at the falling edge after the stimulus. All eight codes are swept against all four pairings of previous and next direction.

// File: rtl/gap_pkg.sv
package gap_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;

  // non-linear idle code: 0,1 direct; above that two clocks per step
  function automatic logic [CNT_W-1:0] idle_clocks(input logic [CODE_W-1:0] code);
    if (code < CODE_W'(2)) return CNT_W'(code);
    else return {code, 1'b0} - CNT_W'(2);
  endfunction
endpackage

// File: rtl/gap_regfile.sv
module gap_regfile #(
  parameter int NUM_AREAS = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter logic [DATA_W-1:0] AREA_RST = 32'h7000_0000
) (
  input  logic                              clk,
  input  logic                              por_rst,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic [NUM_AREAS-1:0][DATA_W-2:0]  cfg,
  output logic                              keep_drv
);
  logic [DATA_W-1:0] rd_next;

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
    always_ff @(posedge clk) begin
      if (por_rst)                                cfg[i] <= AREA_RST[DATA_W-2:0];
      else if (we && addr == ADDR_W'(i))          cfg[i] <= wdata[DATA_W-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst)                                  keep_drv <= 1'b0;
    else if (we && addr == ADDR_W'(NUM_AREAS))    keep_drv <= wdata[0];
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_AREAS; i++)
      if (addr == ADDR_W'(i)) rd_next = {1'b0, cfg[i]};
    if (addr == ADDR_W'(NUM_AREAS)) rd_next[0] = keep_drv;
  end

  always_ff @(posedge clk) begin
    if (por_rst) rdata <= '0;
    else         rdata <= rd_next;
  end

  // R5
  reserved_bit_chk: assert property (@(posedge clk) disable iff (por_rst)
    rdata[DATA_W-1] == 1'b0);
  // R7
  por_default_chk: assert property (@(posedge clk)
    $past(por_rst) |-> cfg[0] == AREA_RST[DATA_W-2:0] && !keep_drv);
endmodule

// File: rtl/gap_area_timer.sv
module gap_area_timer
  import gap_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             hold
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  // a count of one expires this clock, so it no longer blocks
  assign hold = cnt > CNT_W'(1);

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (clr)
    cnt <= CNT_W'(12));
endmodule

// File: rtl/gap_sequencer.sv
module gap_sequencer #(
  parameter int NUM_AREAS = 8,
  parameter int AREA_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [AREA_W-1:0]    req_area,
  input  logic                 req_write,
  input  logic                 cyc_done,
  input  logic [NUM_AREAS-1:0] hold_vec,
  input  logic [NUM_AREAS-1:0] gap_nz_vec,
  output logic                 cyc_start,
  output logic                 busy,
  output logic [AREA_W-1:0]    cur_area,
  output logic                 cur_write,
  output logic                 wr_done
);
  logic ending, free, same_gap, accept;

  assign ending   = busy && cyc_done;
  assign free     = !busy || ending;
  assign wr_done  = ending && cur_write;
  // look ahead: a write finishing now to the requested area with a gap
  assign same_gap = wr_done && cur_area == req_area && gap_nz_vec[cur_area];
  assign accept   = req_valid && !cyc_start && free && !hold_vec[req_area] && !same_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_start <= 1'b0;
      busy      <= 1'b0;
      cur_area  <= '0;
      cur_write <= 1'b0;
    end else begin
      cyc_start <= accept;
      if (accept) begin
        busy      <= 1'b1;
        cur_area  <= req_area;
        cur_write <= req_write;
      end else if (ending) begin
        busy      <= 1'b0;
      end
    end
  end

  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !cyc_start);
  // R8
  held_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && hold_vec[req_area]) |=> !cyc_start);
  // R2
  start_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> $past(req_valid));
endmodule

// File: rtl/bus_turnaround_gap.sv
module bus_turnaround_gap
  import gap_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int DATA_W    = 32,
  parameter int IDLE_LSB  = 28,
  parameter logic [DATA_W-1:0] AREA_RST = 32'h7000_0000,
  localparam int AREA_W   = $clog2(NUM_AREAS),
  localparam int ADDR_W   = $clog2(NUM_AREAS + 1)
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              man_rst,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [AREA_W-1:0] req_area_i,
  input  logic              req_write_i,
  input  logic              cyc_done_i,
  output logic              cyc_start_o,
  output logic [AREA_W-1:0] cyc_area_o,
  output logic              cyc_write_o,
  input  logic              standby_i,
  input  logic              bus_rel_i,
  output logic              strobe_oe_o
);
  logic [NUM_AREAS-1:0][DATA_W-2:0] cfg;
  logic                             keep_drv;
  logic [NUM_AREAS-1:0]             hold_vec, gap_nz_vec;
  logic                             busy, wr_done, seq_rst;

  assign seq_rst = por_rst || man_rst;

  gap_regfile #(.NUM_AREAS(NUM_AREAS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                .AREA_RST(AREA_RST)) u_regs (
    .clk(clk), .por_rst(por_rst), .we(reg_we_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .rdata(reg_rdata_o), .cfg(cfg), .keep_drv(keep_drv));

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_timer
    logic [CNT_W-1:0] idle_n;
    assign idle_n        = idle_clocks(cfg[i][IDLE_LSB +: CODE_W]);
    assign gap_nz_vec[i] = idle_n != '0;
    gap_area_timer u_tmr (
      .clk(clk), .clr(seq_rst),
      .load(wr_done && cyc_area_o == AREA_W'(i)),
      .load_val(idle_n), .hold(hold_vec[i]));
  end

  gap_sequencer #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)) u_seq (
    .clk(clk), .rst(seq_rst), .req_valid(req_valid_i), .req_area(req_area_i),
    .req_write(req_write_i), .cyc_done(cyc_done_i), .hold_vec(hold_vec),
    .gap_nz_vec(gap_nz_vec), .cyc_start(cyc_start_o), .busy(busy),
    .cur_area(cyc_area_o), .cur_write(cyc_write_o), .wr_done(wr_done));

  always_ff @(posedge clk) begin
    if (por_rst) strobe_oe_o <= 1'b0;
    else         strobe_oe_o <= !(standby_i || bus_rel_i) || keep_drv;
  end

  // R6
  oe_active_chk: assert property (@(posedge clk) disable iff (por_rst)
    (!standby_i && !bus_rel_i) |=> strobe_oe_o);
  // R4
  other_area_free_chk: assert property (@(posedge clk) disable iff (seq_rst)
    (wr_done && req_valid_i && req_area_i != cyc_area_o && !cyc_start_o
     && !hold_vec[req_area_i]) |=> cyc_start_o);
endmodule

// File: tb/tb_bus_turnaround_gap.sv
module tb_bus_turnaround_gap;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, man_rst = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0, cyc_done = 1'b0;
  logic [2:0]  req_area = '0, cyc_area;
  logic        cyc_start, cyc_write, standby = 1'b0, bus_rel = 1'b0, strobe_oe;
  int          n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  bus_turnaround_gap dut (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_area_i(req_area), .req_write_i(req_write),
    .cyc_done_i(cyc_done), .cyc_start_o(cyc_start), .cyc_area_o(cyc_area),
    .cyc_write_o(cyc_write), .standby_i(standby), .bus_rel_i(bus_rel),
    .strobe_oe_o(strobe_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dec(input int c);
    return (c < 2) ? c : 2 * c - 2;
  endfunction

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a;
    @(negedge clk); chk(req, reg_rdata, exp);
  endtask

  // present a request at a falling edge; count edges until the start strobe
  task automatic start_cyc(input logic [2:0] a, input logic w, output int lat);
    @(negedge clk); req_valid = 1'b1; req_area = a; req_write = w;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cyc_start && lat < 100);
    req_valid = 1'b0;
  endtask

  // from the start clock: complete next clock, presenting the follow-up request
  task automatic done_then(input logic [2:0] a, input logic w, output int lat);
    @(negedge clk); cyc_done = 1'b1; req_valid = 1'b1; req_area = a; req_write = w;
    lat = 0;
    do begin @(negedge clk); lat++; cyc_done = 1'b0; end
    while (!cyc_start && lat < 100);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk); cyc_done = 1'b1;
    @(negedge clk); cyc_done = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic pair(input string req, input logic [2:0] aa, input logic wa,
                      input logic [2:0] ab, input logic wb, input int exp);
    int l;
    start_cyc(aa, wa, l);
    done_then(ab, wb, l);
    chk(req, l, exp);
    drain();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int l;
    repeat (3) @(negedge clk);
    chk("R9 start in reset", cyc_start, 0);
    chk("R9 oe in reset", strobe_oe, 0);
    por_rst = 1'b0;
    @(negedge clk);
    chk("R9 rdata after reset", reg_rdata, 32'h7000_0000);
    chk("R6 oe active", strobe_oe, 1);
    rd_chk("R7 area default", 4'd5, 32'h7000_0000);
    rd_chk("R7 keep default", 4'd8, 0);
    // R3 first access after reset
    start_cyc(3'd4, 1'b1, l);
    chk("R3 first access", l, 1);
    drain();
    // R5 reserved bit and readback
    wr_reg(4'd6, 32'hFFFF_FFFF);
    rd_chk("R5 reserved bit", 4'd6, 32'h7FFF_FFFF);
    wr_reg(4'd8, 32'hFFFF_FFFF);
    rd_chk("R6 global bits", 4'd8, 32'h1);
    wr_reg(4'd8, 32'h0);
    // R1 R2 R3 sweep: all codes, all direction pairs, same area
    for (int c = 0; c < 8; c++) begin
      wr_reg(4'(c), {1'b0, 3'(c), 28'h0ABC_DE0} | 32'(c));
      rd_chk("R1 code readback", 4'(c), {1'b0, 3'(c), 28'h0ABC_DE0} | 32'(c));
      for (int wa = 0; wa < 2; wa++)
        for (int wb = 0; wb < 2; wb++)
          pair(wa != 0 ? "R2 write then access" : "R3 read then access",
               3'(c), wa[0], 3'(c), wb[0], wa != 0 ? dec(c) + 1 : 1);
    end
    // R4 cross-area
    pair("R4 write other area read", 3'd7, 1'b1, 3'd2, 1'b0, 1);
    pair("R4 write other area write", 3'd7, 1'b1, 3'd0, 1'b1, 1);
    // R8 no accept during the start clock: hold request through it
    @(negedge clk); req_valid = 1'b1; req_area = 3'd1; req_write = 1'b0;
    @(negedge clk);
    chk("R8 start seen", cyc_start, 1);
    cyc_done = 1'b1;
    @(negedge clk); cyc_done = 1'b0;
    chk("R8 no start in start clock", cyc_start, 0);
    @(negedge clk); req_valid = 1'b0;
    chk("R8 restart after done", cyc_start, 1);
    drain();
    // R7 manual reset keeps registers, clears pending idle clocks
    wr_reg(4'd3, 32'h7000_0123);
    start_cyc(3'd3, 1'b1, l);
    @(negedge clk); cyc_done = 1'b1;
    @(negedge clk); cyc_done = 1'b0; man_rst = 1'b1;
    @(negedge clk); man_rst = 1'b0;
    start_cyc(3'd3, 1'b0, l);
    chk("R7 manual reset clears gap", l, 1);
    drain();
    rd_chk("R7 manual reset keeps word", 4'd3, 32'h7000_0123);
    // R6 output-enable
    @(negedge clk); standby = 1'b1;
    @(negedge clk); chk("R6 standby float", strobe_oe, 0);
    standby = 1'b0; bus_rel = 1'b1;
    @(negedge clk); chk("R6 release float", strobe_oe, 0);
    wr_reg(4'd8, 32'h1);
    @(negedge clk); chk("R6 release driven", strobe_oe, 1);
    bus_rel = 1'b0; standby = 1'b1;
    @(negedge clk); chk("R6 standby driven", strobe_oe, 1);
    standby = 1'b0;
    rd_chk("R6 standby keeps word", 4'd3, 32'h7000_0123);
    // R7 power-on reset restores defaults
    @(negedge clk); por_rst = 1'b1;
    @(negedge clk); por_rst = 1'b0;
    rd_chk("R7 por area", 4'd3, 32'h7000_0000);
    rd_chk("R7 por keep", 4'd8, 0);
    pair("R2 por default code 7", 3'd3, 1'b1, 3'd3, 1'b1, 13);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule